// File: doc/BRIEF.md
# Correlator Frame Sequencer with Alternating Header Banks

This block paces a stream of output frames on a divided output clock. Every frame opens with a header period and closes with a payload period. While the header runs, the block reads 16-bit header words out of one of two 240-word banks. The bank changes from one frame to the next. A host can write to either bank at any time. The payload data itself comes from elsewhere: this block only says when a payload word is due.

All sequencing advances on clock cycles in which the rclk enable is high, called ticks below. The host sets four controls: the header length through a 3-bit code, the payload length as a 0-based tick count, a run bit that takes effect only at frame boundaries, and an output prescaler that sets how often a new word is presented. The block gives out the current header word, a payload-valid flag, a one-cycle frame-start strobe and a wrapping frame counter. The length, code and prescale inputs are read live. The host changes them right after a frame-start strobe.

Top module: `frame_sequencer`

## Requirements
- R1: After reset, frameStart, payloadValid, hdrWord and frameCount are all 0. The block is stopped and in tick 0 of a header. The first frame after reset reads bank A.
- R2: The header lasts 240 << hdrCode ticks: code 0 gives 240, code 1 gives 480, code 2 gives 960, code 3 gives 1920 and code 4 gives 3840. Codes 5 to 7 act as code 4.
- R3: A payloadLen of N gives N+1 payload ticks, so a frame lasts (240 << hdrCode) + N + 1 ticks. The next header starts on the tick after the last payload tick.
- R4: frameStart is high for exactly one clock, in the clock after the edge that ends a frame. On that same edge frameCount goes up by one, modulo 2^16.
- R5: Frames are numbered from 1 after reset. Odd frames read bank A (hostBankB=0) and even frames read bank B (hostBankB=1). When frameStart is high, the new frame uses bank B exactly when frameCount is odd.
- R6: In header tick t, the word index is t >> hdrCode. Each word is therefore held for (240 << hdrCode)/240 ticks. A word read at tick t appears on hdrWord after that tick's clock edge.
- R7: While the block is running, a word presented in the payload period has payloadValid=1 and hdrWord=0. A word presented in the header period has payloadValid=0.
- R8: runBit is sampled only on the edge that ends a frame. The whole following frame runs or stays stopped according to that sample. A stopped frame presents hdrWord=0 and payloadValid=0.
- R9: The prescale value p becomes a terminal count T: the smallest value of 0, 1, 3, 7 or 15 that is at least p. A new word is captured on the ticks where a 0-based counter is at 0. The counter advances every tick, wraps after T and restarts at 0 on the first tick of every frame.
- R10: While rclkEn is low, hdrWord, payloadValid, frameCount and the position within the frame do not change, and frameStart stays low.
- R11: A host write (hostWrEn=1) stores hostData at word hostAddr (0 to 239) of the bank chosen by hostBankB, in any cycle. The next read of that word returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rclkEn | input | 1 | Tick enable for the divided output clock |
| payloadLen | input | 29 | Payload length in ticks, 0-based |
| hdrCode | input | 3 | Header length code |
| runBit | input | 1 | Run request, sampled at frame boundaries |
| prescale | input | 4 | Output word prescaler terminal count |
| hostWrEn | input | 1 | Host write strobe for the header banks |
| hostBankB | input | 1 | Host bank select, 0 = bank A, 1 = bank B |
| hostAddr | input | 8 | Host word address within the bank |
| hostData | input | 16 | Host write data |
| hdrWord | output | 16 | Presented header word |
| payloadValid | output | 1 | Presented word belongs to the payload |
| frameStart | output | 1 | One-clock pulse at each frame start |
| frameCount | output | 16 | Count of frame starts since reset |

## Verification
Two conditions are hard to reach from the ports. One is a change to a bank that is not being read, made while the other bank is in use: the write lands mid-frame, and its effect can only be seen one frame later, when the banks swap. The other is a prescaler period that does not divide the frame length, so the phase must be reset at the frame boundary. The bench reaches both by choosing the frame in which it writes and by using a payload length of 12 together with a prescale of 2. A further frame with rclkEn toggling on every clock checks the freeze and the doubled period against frames that run without gaps.

// File: rtl/frameseq_pkg.sv
package frameseq_pkg;
  localparam int HDR_WORDS = 240;
  localparam int ADDR_W    = 8;
  localparam int WORD_W    = 16;
  localparam int PAY_W     = 29;
  localparam int CODE_W    = 3;
  localparam int PRE_W     = 4;
  localparam int CNT_W     = 16;
  localparam int MAX_CODE  = 4;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic              wordCap;  // present a new word on this edge
    logic              loadHdr;  // running and in header period
    logic              loadPay;  // running and in payload period
    logic              bankB;    // bank being read this frame
    logic [ADDR_W-1:0] idx;      // header word index
  } seqStrobe_t;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import frameseq_pkg::*;
#(
  parameter int P_PAY_W    = PAY_W,
  parameter int P_CODE_W   = CODE_W,
  parameter int P_PRE_W    = PRE_W,
  parameter int P_CNT_W    = CNT_W,
  parameter int P_HDR      = HDR_WORDS,
  parameter int P_MAX_CODE = MAX_CODE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rclkEn,
  input  logic [P_PAY_W-1:0]  payloadLen,
  input  logic [P_CODE_W-1:0] hdrCode,
  input  logic                runBit,
  input  logic [P_PRE_W-1:0]  prescale,
  output seqStrobe_t          strobe,
  output logic                frameStart,
  output logic [P_CNT_W-1:0]  frameCount
);
  localparam int HLEN_W = $clog2(P_HDR) + P_MAX_CODE + 1;
  localparam logic [P_CODE_W-1:0] CODE_CAP = P_CODE_W'(P_MAX_CODE);

  logic                inHdr;
  logic                bankB;
  logic                running;
  logic [P_PAY_W-1:0]  pos;
  logic [P_PRE_W-1:0]  preCnt;
  logic [P_PRE_W-1:0]  termEff;
  logic [P_CODE_W-1:0] codeEff;
  logic [HLEN_W-1:0]   hdrLen;
  logic [P_PAY_W-1:0]  idxFull;
  logic                hdrLast;
  logic                payLast;

  // round the prescale up to an all-ones pattern
  for (genvar g = 0; g < P_PRE_W; g++) begin : g_term
    assign termEff[g] = |prescale[P_PRE_W-1:g];
  end

  always_comb begin
    codeEff = (hdrCode > CODE_CAP) ? CODE_CAP : hdrCode;
    hdrLen  = HLEN_W'(P_HDR) << codeEff;
    hdrLast = inHdr && (pos == P_PAY_W'(hdrLen - 1'b1));
    payLast = !inHdr && (pos == payloadLen);
    idxFull = pos >> codeEff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inHdr      <= 1'b1;
      pos        <= '0;
      bankB      <= 1'b0;
      running    <= 1'b0;
      frameCount <= '0;
      preCnt     <= '0;
      frameStart <= 1'b0;
    end else begin
      frameStart <= 1'b0;
      if (rclkEn) begin
        if (hdrLast) begin
          inHdr <= 1'b0;
          pos   <= '0;
        end else if (payLast) begin
          inHdr      <= 1'b1;
          pos        <= '0;
          bankB      <= ~bankB;
          running    <= runBit;
          frameCount <= frameCount + 1'b1;
          frameStart <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
        if (payLast || preCnt == termEff) preCnt <= '0;
        else                              preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.wordCap = rclkEn && (preCnt == '0);
    strobe.loadHdr = running && inHdr;
    strobe.loadPay = running && !inHdr;
    strobe.bankB   = bankB;
    strobe.idx     = idxFull[ADDR_W-1:0];
  end
endmodule

// File: rtl/fseq_data.sv
module fseq_data
  import frameseq_pkg::*;
#(
  parameter int P_WORD_W = WORD_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_HDR    = HDR_WORDS
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                hostWrEn,
  input  logic                hostBankB,
  input  logic [P_ADDR_W-1:0] hostAddr,
  input  logic [P_WORD_W-1:0] hostData,
  output logic [P_WORD_W-1:0] hdrWord,
  output logic                payloadValid
);
  localparam int NBANK = 2;

  logic [P_WORD_W-1:0] rdWord [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [P_WORD_W-1:0] mem [P_HDR];
    always_ff @(posedge clk) begin
      if (hostWrEn && (hostBankB == 1'(b)) && (int'(hostAddr) < P_HDR))
        mem[hostAddr] <= hostData;
    end
    assign rdWord[b] = mem[strobe.idx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrWord      <= '0;
      payloadValid <= 1'b0;
    end else if (strobe.wordCap) begin
      hdrWord      <= strobe.loadHdr ? rdWord[strobe.bankB] : '0;
      payloadValid <= strobe.loadPay;
    end
  end
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import frameseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rclkEn,
  input  logic [PAY_W-1:0]  payloadLen,
  input  logic [CODE_W-1:0] hdrCode,
  input  logic              runBit,
  input  logic [PRE_W-1:0]  prescale,
  input  logic              hostWrEn,
  input  logic              hostBankB,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostData,
  output logic [WORD_W-1:0] hdrWord,
  output logic              payloadValid,
  output logic              frameStart,
  output logic [CNT_W-1:0]  frameCount
);
  seqStrobe_t strobe;

  fseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rclkEn(rclkEn), .payloadLen(payloadLen),
    .hdrCode(hdrCode), .runBit(runBit), .prescale(prescale),
    .strobe(strobe), .frameStart(frameStart), .frameCount(frameCount)
  );

  fseq_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWrEn(hostWrEn),
    .hostBankB(hostBankB), .hostAddr(hostAddr), .hostData(hostData),
    .hdrWord(hdrWord), .payloadValid(payloadValid)
  );
endmodule

// File: rtl/fseq_checker.sv
module fseq_checker
  import frameseq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              rclkEn,
  input logic [WORD_W-1:0] hdrWord,
  input logic              payloadValid,
  input logic              frameStart,
  input logic [CNT_W-1:0]  frameCount
);
  // R4: strobe lasts one clock
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);
  // R4: counter steps with the strobe
  p_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> frameCount == $past(frameCount) + 1'b1);
  // R4: counter holds otherwise
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |-> $stable(frameCount));
  // R10: nothing moves without a tick
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rclkEn |=> ($stable(hdrWord) && $stable(payloadValid) && !frameStart));
  // R7: payload words carry no header value
  p_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    payloadValid |-> hdrWord == '0);
endmodule

bind frame_sequencer fseq_checker u_chk (
  .clk(clk), .rstN(rstN), .rclkEn(rclkEn), .hdrWord(hdrWord),
  .payloadValid(payloadValid), .frameStart(frameStart), .frameCount(frameCount)
);

// File: tb/sim_frame_sequencer.sv
`timescale 1ns/1ps
module sim_frame_sequencer;
  logic        clk = 1'b0;
  logic        rstN;
  logic        rclkEn;
  logic [28:0] payloadLen;
  logic [2:0]  hdrCode;
  logic        runBit;
  logic [3:0]  prescale;
  logic        hostWrEn;
  logic        hostBankB;
  logic [7:0]  hostAddr;
  logic [15:0] hostData;
  logic [15:0] hdrWord;
  logic        payloadValid;
  logic        frameStart;
  logic [15:0] frameCount;

  int total = 0;
  int bad = 0;
  logic [15:0] refA [240];
  logic [15:0] refB [240];

  always #2.5 clk = ~clk;

  frame_sequencer u0 (
    .clk(clk), .rstN(rstN), .rclkEn(rclkEn), .payloadLen(payloadLen),
    .hdrCode(hdrCode), .runBit(runBit), .prescale(prescale),
    .hostWrEn(hostWrEn), .hostBankB(hostBankB), .hostAddr(hostAddr),
    .hostData(hostData), .hdrWord(hdrWord), .payloadValid(payloadValid),
    .frameStart(frameStart), .frameCount(frameCount)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int termOf(input int p);
    if (p == 0) return 0;
    if (p <= 1) return 1;
    if (p <= 3) return 3;
    if (p <= 7) return 7;
    return 15;
  endfunction

  task automatic hostWrite(input bit bnk, input int a, input logic [15:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostBankB = bnk; hostAddr = 8'(a); hostData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
    if (bnk) refB[a] = d; else refA[a] = d;
  endtask

  task automatic test_reset();
    rstN = 1'b0; rclkEn = 1'b1; payloadLen = 29'd9; hdrCode = 3'd0;
    runBit = 1'b0; prescale = 4'd0; hostWrEn = 1'b0; hostBankB = 1'b0;
    hostAddr = '0; hostData = '0;
    for (int i = 0; i < 240; i++) begin
      hostWrite(1'b0, i, 16'hA000 + 16'(i));
      hostWrite(1'b1, i, 16'hB000 + 16'(i));
    end
    @(negedge clk);
    rstN = 1'b1;
    chk(frameStart == 1'b0, "R1 frameStart", 32'(frameStart), 0);
    chk(frameCount == 16'd0, "R1 frameCount", 32'(frameCount), 0);
    chk(hdrWord == 16'd0, "R1 hdrWord", 32'(hdrWord), 0);
    chk(payloadValid == 1'b0, "R1 payloadValid", 32'(payloadValid), 0);
  endtask

  task automatic wait_start();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!frameStart && guard < 20000);
    chk(frameStart == 1'b1, "R3 first frame start", 32'(frameStart), 1);
  endtask

  // precondition: at a negedge where frameStart is high
  task automatic run_frame(input int c, input int n, input int p, input bit expRun,
                           input int wrAt, input bit wrBank, input int wrAddr,
                           input logic [15:0] wrData);
    logic [15:0] cnt0;
    bit useB;
    int hLen, fLen, q, capT, eff;
    logic [15:0] expW;
    bit expPv;
    cnt0 = frameCount;
    useB = frameCount[0];
    hdrCode = 3'(c); payloadLen = 29'(n); prescale = 4'(p);
    eff = (c > 4) ? 4 : c;
    hLen = 240 << eff;
    fLen = hLen + n + 1;
    q = termOf(p) + 1;
    for (int k = 0; k < fLen; k++) begin
      if (k == wrAt) begin
        hostWrEn = 1'b1; hostBankB = wrBank; hostAddr = 8'(wrAddr); hostData = wrData;
      end
      @(posedge clk);
      if (k == wrAt) begin
        if (wrBank) refB[wrAddr] = wrData; else refA[wrAddr] = wrData;
      end
      @(negedge clk);
      hostWrEn = 1'b0;
      capT = k - (k % q);
      if (!expRun) begin
        expW = 16'd0; expPv = 1'b0;
      end else if (capT < hLen) begin
        expW = useB ? refB[capT >> eff] : refA[capT >> eff];
        expPv = 1'b0;
      end else begin
        expW = 16'd0; expPv = 1'b1;
      end
      chk(hdrWord == expW, expRun ? "R5 R6 R9 R11 hdrWord" : "R8 stopped hdrWord",
          32'(hdrWord), 32'(expW));
      chk(payloadValid == expPv, expRun ? "R7 R2 payloadValid" : "R8 stopped payloadValid",
          32'(payloadValid), 32'(expPv));
      chk(frameStart == (k == fLen - 1), "R2 R3 frameStart timing",
          32'(frameStart), 32'(k == fLen - 1));
    end
    chk(frameCount == cnt0 + 16'd1, "R4 frameCount step", 32'(frameCount), 32'(cnt0 + 16'd1));
  endtask

  task automatic gated_frame();
    int cnt = 0;
    logic [15:0] w0;
    bit v0;
    hdrCode = 3'd0; payloadLen = 29'd9; prescale = 4'd0;
    rclkEn = 1'b0;
    forever begin
      w0 = hdrWord; v0 = payloadValid;
      @(posedge clk);
      @(negedge clk);
      cnt++;
      if (!rclkEn) begin
        chk(hdrWord == w0 && payloadValid == v0, "R10 frozen outputs",
            {hdrWord, 15'd0, payloadValid}, {w0, 15'd0, v0});
      end
      if (frameStart || cnt > 2000) break;
      rclkEn = ~rclkEn;
    end
    rclkEn = 1'b1;
    chk(cnt == 500, "R10 gated period", 32'(cnt), 500);
  endtask

  initial begin
    fork
      begin
        test_reset();
        wait_start();
        runBit = 1'b1;
        run_frame(0, 9, 0, 1'b0, -1, 1'b0, 0, 16'h0);
        run_frame(0, 9, 0, 1'b1, -1, 1'b0, 0, 16'h0);
        run_frame(0, 9, 0, 1'b1, 5, 1'b0, 3, 16'h1234);
        run_frame(0, 9, 0, 1'b1, -1, 1'b0, 0, 16'h0);
        run_frame(1, 20, 0, 1'b1, -1, 1'b0, 0, 16'h0);
        run_frame(2, 5, 0, 1'b1, -1, 1'b0, 0, 16'h0);
        runBit = 1'b0;
        run_frame(0, 9, 3, 1'b1, -1, 1'b0, 0, 16'h0);
        run_frame(0, 9, 2, 1'b0, -1, 1'b0, 0, 16'h0);
        runBit = 1'b1;
        run_frame(0, 9, 2, 1'b0, -1, 1'b0, 0, 16'h0);
        run_frame(0, 12, 2, 1'b1, -1, 1'b0, 0, 16'h0);
        gated_frame();
        run_frame(3, 0, 0, 1'b1, -1, 1'b0, 0, 16'h0);
      end
      begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule